// File: doc/BRIEF.md
# Register Producer Map with Rename Credits

This block keeps, for every architectural register, the tag of the youngest in-flight instruction that will write it, together with a valid bit (a producer exists) and a ready bit (that producer has completed). Each rename request presents up to `NUM_SRC` source registers, one optional destination register and the tag of the instruction being renamed. In the same cycle the block returns, for every source, the producer tag, whether a producer exists and whether the operand is ready. For the destination it returns the producer being displaced. At the next clock edge the instruction becomes the producer of its destination.

A credit counter stands for free physical storage. It starts full. Every accepted rename that has a destination consumes one credit, and freed storage is handed back through a return port, with the count capped at its maximum. Rename is refused while no credit is left. A completion port marks every entry that holds the completing tag as ready, and it also bypasses into lookups made in the same cycle. On a squash the restore port replaces the whole map with a committed copy.

Top module: `rename_table`

## Requirements
- R1: After reset every entry has no producer (`src_has_prod`=0, `src_ready`=1, `prev_valid`=0 for any register), `credits` equals `NUM_PHYS`, and `rn_stall`=0.
- R2: For each source port s, `src_tag` slice s and `src_has_prod[s]` give the stored tag and valid bit of the register at `rn_src_idx` slice s. This holds whatever the value of `rn_src_en`, and the lookup is combinational.
- R3: `src_ready[s]` is 1 when the entry has no producer, or when its producer completed in an earlier cycle. Otherwise it is 0.
- R4: A completion (`cmp_valid`, `cmp_tag`) whose tag equals a looked-up producer tag makes that source ready in the same cycle.
- R5: `rn_issuable` is 1 exactly when every source with its `rn_src_en` bit set is ready. With no source enabled it is 1.
- R6: `prev_tag`/`prev_valid` show the current entry of `rn_dst_idx` in the same cycle. After an accepted rename with `rn_dst_en`=1, the entry holds `rn_tag`, valid and not ready from the next cycle on. Lookups by the same instruction see the old entry.
- R7: Each accepted rename with `rn_dst_en`=1 lowers `credits` by one. A rename with no destination leaves `credits` unchanged.
- R8: While `credits` is 0, `rn_stall`=1 and `rn_accept`=0, and the map is left unchanged. Otherwise `rn_accept` = `rn_valid` and not `sq_restore`.
- R9: When `free_valid`=1, `free_num` is added to `credits`. The result, taken after any same-cycle decrement, is capped at `NUM_PHYS`. The stall clears in the cycle after a return that lifts the count above zero.
- R10: When `sq_restore`=1, every entry e takes tag `sq_tags[e*TAG_W +: TAG_W]` and valid `sq_valid[e]` at the next edge, with its ready bit set. That cycle's rename is refused and consumes no credit.
- R11: A completion marks every entry holding `cmp_tag` ready. If a rename overwrites an entry in that same cycle, the new producer wins and the entry is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rn_valid | input | 1 | Rename request present |
| rn_src_en | input | NUM_SRC | Per-source use flag |
| rn_src_idx | input | NUM_SRC*IDX_W | Source register numbers, port s at slice s |
| rn_dst_en | input | 1 | Instruction writes a register |
| rn_dst_idx | input | IDX_W | Destination register number |
| rn_tag | input | TAG_W | Tag of the instruction being renamed |
| rn_accept | output | 1 | Rename taken this cycle |
| rn_stall | output | 1 | No credit left |
| src_tag | output | NUM_SRC*TAG_W | Producer tag per source |
| src_has_prod | output | NUM_SRC | Source has an in-flight producer |
| src_ready | output | NUM_SRC | Source operand ready |
| rn_issuable | output | 1 | All enabled sources ready |
| prev_tag | output | TAG_W | Displaced producer tag of the destination |
| prev_valid | output | 1 | Displaced producer existed |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | TAG_W | Completing tag |
| free_valid | input | 1 | Credit return strobe |
| free_num | input | CNT_W | Credits returned |
| sq_restore | input | 1 | Load the committed copy |
| sq_tags | input | NUM_ARCH*TAG_W | Committed tags, entry e at slice e |
| sq_valid | input | NUM_ARCH | Committed valid bits |
| credits | output | CNT_W | Current credit count |

## Verification
Completion can land in the same cycle as a rename that reads the completing tag, and in the same cycle as a rename that overwrites an entry holding that tag. The bench draws tags and register numbers from narrow ranges, so these collisions happen often, and it also forces them in directed steps. A credit return can likewise coincide with a credit-consuming rename, and this is driven directly at the cap. A reference model in the bench predicts the bypassed ready bit and the post-edge entry state, and it compares the next cycle's lookups of that register against them.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
   // per-cycle action applied to the map storage
   typedef enum logic [1:0] {
      OP_KEEP  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_WRITE = 2'd2
   } tbl_op_e;
endpackage

// File: rtl/rt_credit.sv
`timescale 1ns/1ps
module rt_credit #(
   parameter int NUM_PHYS = 64,
   parameter int CNT_W    = $clog2(NUM_PHYS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             give_en,
   input  logic [CNT_W-1:0] give_num,
   output logic [CNT_W-1:0] count,
   output logic             empty
);
   localparam int SUM_W = CNT_W + 1;
   localparam logic [SUM_W-1:0] CAP_S = SUM_W'(NUM_PHYS);

   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      sum = {1'b0, count}
          + (give_en ? {1'b0, give_num} : '0)
          - {{CNT_W{1'b0}}, take};
      if (sum > CAP_S) nxt = CNT_W'(NUM_PHYS);
      else             nxt = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= CNT_W'(NUM_PHYS);
      else        count <= nxt;
   end

   assign empty = (count == '0);
endmodule

// File: rtl/rt_map.sv
`timescale 1ns/1ps
module rt_map
   import rt_pkg::*;
#(
   parameter int NUM_ARCH = 32,
   parameter int TAG_W    = 8,
   parameter int IDX_W    = $clog2(NUM_ARCH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  tbl_op_e                   op,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [TAG_W-1:0]          wr_tag,
   input  logic                      done_en,
   input  logic [TAG_W-1:0]          done_tag,
   input  logic [NUM_ARCH*TAG_W-1:0] ld_tags,
   input  logic [NUM_ARCH-1:0]       ld_valid,
   output logic [TAG_W-1:0]          e_tag [NUM_ARCH],
   output logic                      e_val [NUM_ARCH],
   output logic                      e_rdy [NUM_ARCH]
);
   for (genvar e = 0; e < NUM_ARCH; e++) begin : g_ent
      logic hit_wr;
      assign hit_wr = (op == OP_WRITE) && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_tag[e] <= '0;
            e_val[e] <= 1'b0;
            e_rdy[e] <= 1'b1;
         end else if (op == OP_LOAD) begin
            e_tag[e] <= ld_tags[e*TAG_W +: TAG_W];
            e_val[e] <= ld_valid[e];
            e_rdy[e] <= 1'b1;
         end else if (hit_wr) begin
            e_tag[e] <= wr_tag;
            e_val[e] <= 1'b1;
            e_rdy[e] <= 1'b0;
         end else if (done_en && (e_tag[e] == done_tag)) begin
            e_rdy[e] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rt_lookup.sv
`timescale 1ns/1ps
module rt_lookup #(
   parameter int NUM_ARCH = 32,
   parameter int TAG_W    = 8,
   parameter int IDX_W    = $clog2(NUM_ARCH)
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] e_tag [NUM_ARCH],
   input  logic             e_val [NUM_ARCH],
   input  logic             e_rdy [NUM_ARCH],
   input  logic             done_en,
   input  logic [TAG_W-1:0] done_tag,
   output logic [TAG_W-1:0] tag,
   output logic             has,
   output logic             ready
);
   logic bypass;
   assign tag    = e_tag[idx];
   assign has    = e_val[idx];
   assign bypass = done_en && (done_tag == tag);
   assign ready  = !has || e_rdy[idx] || bypass;
endmodule

// File: rtl/rename_table.sv
`timescale 1ns/1ps
module rename_table
   import rt_pkg::*;
#(
   parameter int  NUM_ARCH = 32,
   parameter int  TAG_W    = 8,
   parameter int  NUM_SRC  = 2,
   parameter int  NUM_PHYS = 64,
   localparam int IDX_W    = $clog2(NUM_ARCH),
   localparam int CNT_W    = $clog2(NUM_PHYS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rn_valid,
   input  logic [NUM_SRC-1:0]        rn_src_en,
   input  logic [NUM_SRC*IDX_W-1:0]  rn_src_idx,
   input  logic                      rn_dst_en,
   input  logic [IDX_W-1:0]          rn_dst_idx,
   input  logic [TAG_W-1:0]          rn_tag,
   output logic                      rn_accept,
   output logic                      rn_stall,
   output logic [NUM_SRC*TAG_W-1:0]  src_tag,
   output logic [NUM_SRC-1:0]        src_has_prod,
   output logic [NUM_SRC-1:0]        src_ready,
   output logic                      rn_issuable,
   output logic [TAG_W-1:0]          prev_tag,
   output logic                      prev_valid,
   input  logic                      cmp_valid,
   input  logic [TAG_W-1:0]          cmp_tag,
   input  logic                      free_valid,
   input  logic [CNT_W-1:0]          free_num,
   input  logic                      sq_restore,
   input  logic [NUM_ARCH*TAG_W-1:0] sq_tags,
   input  logic [NUM_ARCH-1:0]       sq_valid,
   output logic [CNT_W-1:0]          credits
);
   // elaboration-time parameter checks
   if (NUM_ARCH < 2 || (NUM_ARCH & (NUM_ARCH - 1)) != 0) begin : g_bad_arch
      $error("NUM_ARCH must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be positive");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be positive");
   end
   if (NUM_PHYS < 1) begin : g_bad_phys
      $error("NUM_PHYS must be positive");
   end

   logic [TAG_W-1:0] e_tag [NUM_ARCH];
   logic             e_val [NUM_ARCH];
   logic             e_rdy [NUM_ARCH];
   logic             no_credit;
   tbl_op_e          op;

   assign rn_stall  = no_credit;
   assign rn_accept = rn_valid && !no_credit && !sq_restore;

   always_comb begin
      if (sq_restore)                  op = OP_LOAD;
      else if (rn_accept && rn_dst_en) op = OP_WRITE;
      else                             op = OP_KEEP;
   end

   rt_credit #(.NUM_PHYS(NUM_PHYS), .CNT_W(CNT_W)) u_credit (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (rn_accept && rn_dst_en),
      .give_en  (free_valid),
      .give_num (free_num),
      .count    (credits),
      .empty    (no_credit)
   );

   rt_map #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .wr_idx   (rn_dst_idx),
      .wr_tag   (rn_tag),
      .done_en  (cmp_valid),
      .done_tag (cmp_tag),
      .ld_tags  (sq_tags),
      .ld_valid (sq_valid),
      .e_tag    (e_tag),
      .e_val    (e_val),
      .e_rdy    (e_rdy)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      rt_lookup #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_rd (
         .idx      (rn_src_idx[s*IDX_W +: IDX_W]),
         .e_tag    (e_tag),
         .e_val    (e_val),
         .e_rdy    (e_rdy),
         .done_en  (cmp_valid),
         .done_tag (cmp_tag),
         .tag      (src_tag[s*TAG_W +: TAG_W]),
         .has      (src_has_prod[s]),
         .ready    (src_ready[s])
      );
   end

   assign rn_issuable = &(src_ready | ~rn_src_en);
   assign prev_tag    = e_tag[rn_dst_idx];
   assign prev_valid  = e_val[rn_dst_idx];
endmodule

// File: rtl/rename_table_chk.sv
`timescale 1ns/1ps
module rename_table_chk #(
   parameter int NUM_SRC  = 2,
   parameter int TAG_W    = 8,
   parameter int IDX_W    = 5,
   parameter int NUM_PHYS = 64,
   parameter int CNT_W    = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_SRC-1:0]       rn_src_en,
   input logic [NUM_SRC*IDX_W-1:0] rn_src_idx,
   input logic                     rn_dst_en,
   input logic [IDX_W-1:0]         rn_dst_idx,
   input logic [TAG_W-1:0]         rn_tag,
   input logic                     rn_accept,
   input logic                     rn_stall,
   input logic [NUM_SRC*TAG_W-1:0] src_tag,
   input logic [NUM_SRC-1:0]       src_has_prod,
   input logic [NUM_SRC-1:0]       src_ready,
   input logic                     rn_issuable,
   input logic                     cmp_valid,
   input logic [TAG_W-1:0]         cmp_tag,
   input logic                     free_valid,
   input logic                     sq_restore,
   input logic [CNT_W-1:0]         credits
);
   AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      credits <= CNT_W'(NUM_PHYS)); // R9
   AST_STALL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (credits == '0) |-> rn_stall); // R8
   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      rn_stall |-> !rn_accept); // R8
   AST_CREDIT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_accept && rn_dst_en && !free_valid) |=> (credits == $past(credits) - CNT_W'(1))); // R7
   AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_src_en == '0) |-> rn_issuable); // R5
   AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && src_has_prod[0] && src_tag[TAG_W-1:0] == cmp_tag) |-> src_ready[0]); // R4
   AST_RESTORE_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      sq_restore |-> !rn_accept); // R10
   AST_NEW_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_accept && rn_dst_en) |=> ((rn_src_idx[IDX_W-1:0] != $past(rn_dst_idx)) ||
                                    (src_has_prod[0] && src_tag[TAG_W-1:0] == $past(rn_tag)))); // R6
   AST_NEW_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_accept && rn_dst_en) |=> ((rn_src_idx[IDX_W-1:0] != $past(rn_dst_idx)) ||
                                    (cmp_valid && cmp_tag == $past(rn_tag)) || !src_ready[0])); // R11
endmodule

bind rename_table rename_table_chk #(
   .NUM_SRC(NUM_SRC), .TAG_W(TAG_W), .IDX_W(IDX_W), .NUM_PHYS(NUM_PHYS), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rn_src_en(rn_src_en), .rn_src_idx(rn_src_idx),
   .rn_dst_en(rn_dst_en), .rn_dst_idx(rn_dst_idx), .rn_tag(rn_tag),
   .rn_accept(rn_accept), .rn_stall(rn_stall), .src_tag(src_tag),
   .src_has_prod(src_has_prod), .src_ready(src_ready), .rn_issuable(rn_issuable),
   .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .free_valid(free_valid),
   .sq_restore(sq_restore), .credits(credits)
);

// File: tb/sim_rename_table.sv
`timescale 1ns/1ps
module sim_rename_table;
   localparam int NUM_ARCH = 32;
   localparam int TAG_W    = 8;
   localparam int NUM_SRC  = 2;
   localparam int NUM_PHYS = 64;
   localparam int IDX_W    = $clog2(NUM_ARCH);
   localparam int CNT_W    = $clog2(NUM_PHYS + 1);

   logic                      clk = 1'b0;
   logic                      rst_n;
   logic                      rn_valid;
   logic [NUM_SRC-1:0]        rn_src_en;
   logic [NUM_SRC*IDX_W-1:0]  rn_src_idx;
   logic                      rn_dst_en;
   logic [IDX_W-1:0]          rn_dst_idx;
   logic [TAG_W-1:0]          rn_tag;
   logic                      rn_accept, rn_stall, rn_issuable, prev_valid;
   logic [NUM_SRC*TAG_W-1:0]  src_tag;
   logic [NUM_SRC-1:0]        src_has_prod, src_ready;
   logic [TAG_W-1:0]          prev_tag;
   logic                      cmp_valid;
   logic [TAG_W-1:0]          cmp_tag;
   logic                      free_valid;
   logic [CNT_W-1:0]          free_num;
   logic                      sq_restore;
   logic [NUM_ARCH*TAG_W-1:0] sq_tags;
   logic [NUM_ARCH-1:0]       sq_valid;
   logic [CNT_W-1:0]          credits;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   // reference model
   logic [TAG_W-1:0] m_tag [NUM_ARCH];
   logic             m_val [NUM_ARCH];
   logic             m_rdy [NUM_ARCH];
   int               m_cred;

   always #5 clk = ~clk;

   rename_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .NUM_SRC(NUM_SRC), .NUM_PHYS(NUM_PHYS)) u0 (
      .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_src_en(rn_src_en),
      .rn_src_idx(rn_src_idx), .rn_dst_en(rn_dst_en), .rn_dst_idx(rn_dst_idx),
      .rn_tag(rn_tag), .rn_accept(rn_accept), .rn_stall(rn_stall), .src_tag(src_tag),
      .src_has_prod(src_has_prod), .src_ready(src_ready), .rn_issuable(rn_issuable),
      .prev_tag(prev_tag), .prev_valid(prev_valid), .cmp_valid(cmp_valid),
      .cmp_tag(cmp_tag), .free_valid(free_valid), .free_num(free_num),
      .sq_restore(sq_restore), .sq_tags(sq_tags), .sq_valid(sq_valid), .credits(credits)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
      end
   endtask

   function automatic logic exp_ready(input int idx);
      return !m_val[idx] || m_rdy[idx] || (cmp_valid && cmp_tag == m_tag[idx]);
   endfunction

   function automatic logic exp_accept();
      return rn_valid && (m_cred != 0) && !sq_restore;
   endfunction

   task automatic idle_inputs();
      rn_valid = 0; rn_src_en = '0; rn_src_idx = '0; rn_dst_en = 0; rn_dst_idx = '0;
      rn_tag = '0; cmp_valid = 0; cmp_tag = '0; free_valid = 0; free_num = '0;
      sq_restore = 0; sq_tags = '0; sq_valid = '0;
   endtask

   // inputs are already applied after a falling edge; check, update model, advance
   task automatic step();
      logic iss;
      int   tmp;
      #2;
      iss = 1'b1;
      for (int s = 0; s < NUM_SRC; s++) begin
         int ix;
         ix = int'(rn_src_idx[s*IDX_W +: IDX_W]);
         chk("R2 tag", 32'(src_tag[s*TAG_W +: TAG_W]), 32'(m_tag[ix]));
         chk("R2 has", 32'(src_has_prod[s]), 32'(m_val[ix]));
         chk("R3/R4 ready", 32'(src_ready[s]), 32'(exp_ready(ix)));
         if (rn_src_en[s] && !exp_ready(ix)) iss = 1'b0;
      end
      chk("R5 issuable", 32'(rn_issuable), 32'(iss));
      chk("R6 prev_tag", 32'(prev_tag), 32'(m_tag[int'(rn_dst_idx)]));
      chk("R6 prev_valid", 32'(prev_valid), 32'(m_val[int'(rn_dst_idx)]));
      chk("R8 stall", 32'(rn_stall), 32'(m_cred == 0));
      chk("R8/R10 accept", 32'(rn_accept), 32'(exp_accept()));
      chk("R7/R9 credits", 32'(credits), 32'(m_cred));
      // model next state
      tmp = m_cred + (free_valid ? int'(free_num) : 0) - ((exp_accept() && rn_dst_en) ? 1 : 0);
      if (sq_restore) begin
         for (int e = 0; e < NUM_ARCH; e++) begin
            m_tag[e] = sq_tags[e*TAG_W +: TAG_W];
            m_val[e] = sq_valid[e];
            m_rdy[e] = 1'b1;
         end
      end else begin
         if (cmp_valid)
            for (int e = 0; e < NUM_ARCH; e++)
               if (m_tag[e] == cmp_tag) m_rdy[e] = 1'b1;
         if (exp_accept() && rn_dst_en) begin
            m_tag[int'(rn_dst_idx)] = rn_tag;
            m_val[int'(rn_dst_idx)] = 1'b1;
            m_rdy[int'(rn_dst_idx)] = 1'b0;
         end
      end
      m_cred = (tmp > NUM_PHYS) ? NUM_PHYS : tmp;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic rename(input int s0, input int s1, input logic [1:0] en,
                         input logic de, input int d, input int tg);
      rn_valid = 1; rn_src_en = en;
      rn_src_idx = {IDX_W'(s1), IDX_W'(s0)};
      rn_dst_en = de; rn_dst_idx = IDX_W'(d); rn_tag = TAG_W'(tg);
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int e = 0; e < NUM_ARCH; e++) begin
         m_tag[e] = '0; m_val[e] = 1'b0; m_rdy[e] = 1'b1;
      end
      m_cred = NUM_PHYS;
      idle_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state, every register looked up
      for (int r = 0; r < NUM_ARCH; r += 2) begin
         rn_src_idx = {IDX_W'(r + 1), IDX_W'(r)};
         rn_dst_idx = IDX_W'(r);
         #2;
         chk("R1 has", 32'(src_has_prod), 32'h0);
         chk("R1 ready", 32'(src_ready), 32'h3);
         chk("R1 prev_valid", 32'(prev_valid), 32'h0);
         chk("R1 credits", 32'(credits), 32'(NUM_PHYS));
         step();
      end

      // R6: rename r3 with tag 0x11, same instruction reads r3 (old entry)
      rename(3, 0, 2'b01, 1, 3, 'h11); step();
      // R3: r3 now pending, not ready
      rename(3, 3, 2'b11, 0, 0, 'h12);
      #2; chk("R3 pending", 32'(src_ready), 32'h0); chk("R6 new tag", 32'(src_tag[7:0]), 32'h11);
      step();
      // R4: completion bypass in same cycle
      rename(3, 1, 2'b11, 0, 0, 'h13); cmp_valid = 1; cmp_tag = 'h11;
      #2; chk("R4 bypass", 32'(src_ready[0]), 32'h1); chk("R5 bypass issuable", 32'(rn_issuable), 32'h1);
      step();
      rename(3, 1, 2'b01, 0, 0, 'h14); step();
      // R5: zero sources issuable
      rename(3, 3, 2'b00, 0, 0, 'h15); step();
      // R11: overwrite r5 while its old producer completes
      rename(0, 0, 2'b00, 1, 5, 'h21); step();
      rename(5, 0, 2'b01, 1, 5, 'h22); cmp_valid = 1; cmp_tag = 'h21; step();
      rename(5, 0, 2'b01, 0, 0, 'h23);
      #2; chk("R11 new producer wins", 32'(src_ready[0]), 32'h0);
      step();

      // R7/R8: drain credits
      for (int k = 0; k < 100 && m_cred > 0; k++) begin
         rename(k % 8, (k + 1) % 8, 2'b11, 1, k % 8, k + 40); step();
      end
      rename(2, 2, 2'b01, 1, 2, 'hEE);
      #2; chk("R8 stall at zero", 32'(rn_stall), 32'h1); chk("R8 no accept", 32'(rn_accept), 32'h0);
      step();
      rename(2, 2, 2'b01, 1, 2, 'hEF);
      #2; chk("R8 map unchanged", 32'(src_tag[7:0] != 8'hEE), 32'h1);
      step();
      // R9: return lifts stall next cycle, then cap
      free_valid = 1; free_num = CNT_W'(3); step();
      rename(1, 1, 2'b00, 0, 0, 0);
      #2; chk("R9 stall cleared", 32'(rn_stall), 32'h0); chk("R9 add", 32'(credits), 32'h3);
      step();
      rename(1, 1, 2'b00, 1, 9, 'h30); free_valid = 1; free_num = CNT_W'(63); step();
      #2; chk("R9 cap", 32'(credits), 32'(NUM_PHYS));
      step();

      // R10: restore with a rename in the same cycle
      for (int e = 0; e < NUM_ARCH; e++) begin
         sq_tags[e*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 15));
         sq_valid[e] = 1'($urandom_range(0, 1));
      end
      rename(4, 6, 2'b11, 1, 4, 'h77); sq_restore = 1;
      #2; chk("R10 refuse", 32'(rn_accept), 32'h0);
      step();
      for (int r = 0; r < NUM_ARCH; r += 2) begin
         rn_src_idx = {IDX_W'(r + 1), IDX_W'(r)}; step();
      end

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic wide;
         wide = ($urandom_range(0, 9) == 0);
         rn_valid   = ($urandom_range(0, 9) < 7);
         rn_src_en  = NUM_SRC'($urandom_range(0, 3));
         rn_src_idx = {IDX_W'(wide ? $urandom_range(0, 31) : $urandom_range(0, 7)),
                       IDX_W'(wide ? $urandom_range(0, 31) : $urandom_range(0, 7))};
         rn_dst_en  = ($urandom_range(0, 9) < 8);
         rn_dst_idx = IDX_W'(wide ? $urandom_range(0, 31) : $urandom_range(0, 7));
         rn_tag     = TAG_W'($urandom_range(0, 15));
         cmp_valid  = ($urandom_range(0, 9) < 4);
         cmp_tag    = TAG_W'($urandom_range(0, 15));
         free_valid = ($urandom_range(0, 99) < 15);
         free_num   = CNT_W'($urandom_range(1, 6));
         sq_restore = ($urandom_range(0, 199) == 0);
         for (int e = 0; e < NUM_ARCH; e++) begin
            sq_tags[e*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 15));
            sq_valid[e] = 1'($urandom_range(0, 1));
         end
         step();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule